// File: doc/BRIEF.md
# Line-Bounded Instruction Fetch Request Generator

This block turns a scheduler grant into an instruction-fetch read request for an address translation port. On each grant it receives the program counter of the chosen slot, the number of instructions already held in that slot's buffer, and the slot's base pointer. It then forms a byte address for the next instruction to fetch. Each instruction slot is 8 bytes wide. The request size is chosen so that the fetch ends at the end of the current cache line. A misaligned fetch is cut short at that line end; it is never split into two requests.

The request leaves on a valid/ready port. It is offered in the same cycle it arrives when nothing is waiting. An offer seen with ready low counts as a rejection. The block then marks the port as stalled and keeps the request in an in-order retry queue. While the port is stalled, new requests go straight into the queue. A one-cycle retry pulse clears the stall. After that, queued requests are offered oldest first, ahead of any new grant. Every request carries the slot index so that the response can be matched back to its slot.

Top module: `fetch_req_gen`

## Requirements
- R1: The request address equals basePtr + 8 * (pc + occupancy). The sum pc + occupancy is counted in 8-byte instruction slots.
- R2: When the address is a multiple of the line size (64 bytes by default), the request size is one full line.
- R3: When the address is not line-aligned, the request size is the line size minus (address mod line size), so the request ends exactly at the line end.
- R4: Each request carries, on portSlot, the slot index that was given with its grant.
- R5: When the port is not stalled and the retry queue is empty, a grant is offered on the port in the same cycle. If portReady is high in that cycle, the request is consumed and nothing is queued.
- R6: An offer with portReady low marks the port stalled from the next cycle, and the rejected request is kept for retry.
- R7: While the port is stalled, portValid stays low, and every grant is appended to the retry queue.
- R8: A retryPulse clears the stall from the next cycle. Queued requests are then offered oldest first, before any new grant. A queued request rejected again stays at the head and the port re-stalls.
- R9: The retry queue holds NUM_SLOTS requests and drains them in arrival order after being completely filled.
- R10: After reset, portValid is low, the port is not stalled and the retry queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grantValid | input | 1 | A slot has been granted a fetch this cycle |
| grantSlot | input | SLOT_W | Index of the granted slot |
| grantPc | input | PC_W | Program counter of the slot, in instruction slots |
| grantOcc | input | OCC_W | Instructions already buffered for the slot |
| grantBase | input | ADDR_W | Byte base pointer of the slot's code |
| portValid | output | 1 | Request offered to the translation port |
| portReady | input | 1 | Port accepts the offered request |
| portAddr | output | ADDR_W | Byte address of the request |
| portSize | output | SZ_W | Byte count of the request, 1 to LINE_BYTES |
| portSlot | output | SLOT_W | Slot tag of the request |
| retryPulse | input | 1 | Port can accept again; clears the stall |

## Verification
The bench uses the defaults: four slots, a 64-byte line and 8-byte instruction slots. With these values an address lands within eight possible offsets of a line end, so both the full-line and the trimmed sizes down to 8 bytes can be reached with small program counters. A depth of four lets a short run of stalled grants fill the retry queue completely. The run also covers a head request that is rejected a second time after a retry, and a new grant that arrives while older entries are draining and must queue behind them.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic selHead;  // port shows queue head instead of new grant
    logic pushNew;  // append the current grant to the retry queue
    logic popHead;  // head was accepted by the port
  } fgenStrobes_t;
endpackage

// File: rtl/fgen_datapath.sv
module fgen_datapath
  import fgen_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 16,
  parameter int OCC_W      = 4,
  parameter int LINE_BYTES = 64,
  parameter int INST_BYTES = 8,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SZ_W      = $clog2(LINE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fgenStrobes_t      strobes,
  input  logic [SLOT_W-1:0] grantSlot,
  input  logic [PC_W-1:0]   grantPc,
  input  logic [OCC_W-1:0]  grantOcc,
  input  logic [ADDR_W-1:0] grantBase,
  output logic [ADDR_W-1:0] portAddr,
  output logic [SZ_W-1:0]   portSize,
  output logic [SLOT_W-1:0] portSlot,
  output logic              qEmpty,
  output logic              qFull
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int INST_SH = $clog2(INST_BYTES);
  localparam int ENT_W   = ADDR_W + SZ_W + SLOT_W;
  localparam int PTR_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CNT_W   = $clog2(NUM_SLOTS + 1);

  // address and line-bounded size of the incoming grant
  logic [ADDR_W-1:0]  fetchIdx;
  logic [ADDR_W-1:0]  newAddr;
  logic [LINE_SH-1:0] lineOff;
  logic [SZ_W-1:0]    newSize;

  always_comb begin
    fetchIdx = ADDR_W'(grantPc) + ADDR_W'(grantOcc);
    newAddr  = grantBase + (fetchIdx << INST_SH);
    lineOff  = newAddr[LINE_SH-1:0];
    if (lineOff == '0) newSize = SZ_W'(LINE_BYTES);
    else               newSize = SZ_W'(LINE_BYTES) - SZ_W'(lineOff);
  end

  // in-order retry queue
  logic [ENT_W-1:0] qMem [NUM_SLOTS];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] qCount;
  logic [ENT_W-1:0] headEnt;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    if (32'(p) == NUM_SLOTS - 1) return '0;
    return p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strobes.pushNew) wrPtr <= ptrInc(wrPtr);
      if (strobes.popHead) rdPtr <= ptrInc(rdPtr);
      case ({strobes.pushNew, strobes.popHead})
        2'b10:   qCount <= qCount + CNT_W'(1);
        2'b01:   qCount <= qCount - CNT_W'(1);
        default: qCount <= qCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.pushNew) qMem[wrPtr] <= {newAddr, newSize, grantSlot};
  end

  assign headEnt = qMem[rdPtr];
  assign qEmpty  = (qCount == '0);
  assign qFull   = (32'(qCount) == NUM_SLOTS);

  // port field select
  always_comb begin
    if (strobes.selHead) begin
      {portAddr, portSize, portSlot} = headEnt;
    end else begin
      portAddr = newAddr;
      portSize = newSize;
      portSlot = grantSlot;
    end
  end
endmodule

// File: rtl/fgen_control.sv
module fgen_control
  import fgen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         grantValid,
  input  logic         portReady,
  input  logic         retryPulse,
  input  logic         qEmpty,
  output logic         portValid,
  output logic         stallFlag,
  output fgenStrobes_t strobes
);
  logic useHead, useNew;

  always_comb begin
    useHead         = !stallFlag && !qEmpty;
    useNew          = !stallFlag && qEmpty && grantValid;
    portValid       = useHead || useNew;
    strobes.selHead = useHead;
    strobes.popHead = useHead && portReady;
    strobes.pushNew = grantValid && !(useNew && portReady);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stallFlag <= 1'b0;
    else       stallFlag <= (portValid && !portReady) || (stallFlag && !retryPulse);
  end
endmodule

// File: rtl/fetch_req_gen.sv
module fetch_req_gen
  import fgen_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 16,
  parameter int OCC_W      = 4,
  parameter int LINE_BYTES = 64,
  parameter int INST_BYTES = 8,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SZ_W      = $clog2(LINE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              grantValid,
  input  logic [SLOT_W-1:0] grantSlot,
  input  logic [PC_W-1:0]   grantPc,
  input  logic [OCC_W-1:0]  grantOcc,
  input  logic [ADDR_W-1:0] grantBase,
  output logic              portValid,
  input  logic              portReady,
  output logic [ADDR_W-1:0] portAddr,
  output logic [SZ_W-1:0]   portSize,
  output logic [SLOT_W-1:0] portSlot,
  input  logic              retryPulse
);
  fgenStrobes_t strobes;
  logic         qEmpty, qFull, stallFlag;

  fgen_control uCtrl (
    .clk(clk), .rstN(rstN), .grantValid(grantValid), .portReady(portReady),
    .retryPulse(retryPulse), .qEmpty(qEmpty), .portValid(portValid),
    .stallFlag(stallFlag), .strobes(strobes)
  );

  fgen_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .PC_W(PC_W), .OCC_W(OCC_W),
    .LINE_BYTES(LINE_BYTES), .INST_BYTES(INST_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .grantSlot(grantSlot),
    .grantPc(grantPc), .grantOcc(grantOcc), .grantBase(grantBase),
    .portAddr(portAddr), .portSize(portSize), .portSlot(portSlot),
    .qEmpty(qEmpty), .qFull(qFull)
  );
endmodule

// File: rtl/fetch_req_gen_chk.sv
module fetch_req_gen_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int SZ_W      = $clog2(LINE_BYTES) + 1,
  localparam int LINE_SH   = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              portValid,
  input logic              portReady,
  input logic [ADDR_W-1:0] portAddr,
  input logic [SZ_W-1:0]   portSize,
  input logic              retryPulse,
  input logic              stallFlag,
  input logic              qFull,
  input logic              grantValid
);
  // R3
  line_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    portValid |-> (portSize != '0) &&
      ((SZ_W+1)'(portAddr[LINE_SH-1:0]) + (SZ_W+1)'(portSize) <= (SZ_W+1)'(LINE_BYTES)));

  // R6
  reject_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    portValid && !portReady |=> stallFlag);

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallFlag |-> !portValid);

  // R8
  retry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallFlag && retryPulse |=> !stallFlag);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallFlag && !retryPulse |=> stallFlag);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    qFull |-> !grantValid || (portValid && !stallFlag));
endmodule

bind fetch_req_gen fetch_req_gen_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .portValid(portValid), .portReady(portReady),
  .portAddr(portAddr), .portSize(portSize), .retryPulse(retryPulse),
  .stallFlag(stallFlag), .qFull(qFull), .grantValid(grantValid)
);

// File: tb/tb_fetch_req_gen.sv
module tb_fetch_req_gen;
  localparam int NUM_SLOTS = 4, ADDR_W = 32, PC_W = 16, OCC_W = 4;
  localparam int LINE_BYTES = 64, SLOT_W = 2, SZ_W = 7;

  logic              clk = 1'b0, rstN = 1'b0;
  logic              grantValid = 1'b0, portReady = 1'b0, retryPulse = 1'b0;
  logic [SLOT_W-1:0] grantSlot = '0;
  logic [PC_W-1:0]   grantPc = '0;
  logic [OCC_W-1:0]  grantOcc = '0;
  logic [ADDR_W-1:0] grantBase = '0;
  logic              portValid;
  logic [ADDR_W-1:0] portAddr;
  logic [SZ_W-1:0]   portSize;
  logic [SLOT_W-1:0] portSlot;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fetch_req_gen dut (
    .clk(clk), .rstN(rstN), .grantValid(grantValid), .grantSlot(grantSlot),
    .grantPc(grantPc), .grantOcc(grantOcc), .grantBase(grantBase),
    .portValid(portValid), .portReady(portReady), .portAddr(portAddr),
    .portSize(portSize), .portSlot(portSlot), .retryPulse(retryPulse)
  );

  function automatic logic [ADDR_W-1:0] expAddr(input logic [ADDR_W-1:0] b,
                                                input int pc, input int occ);
    return b + ADDR_W'((pc + occ) * 8);
  endfunction

  function automatic logic [SZ_W-1:0] expSize(input logic [ADDR_W-1:0] a);
    int rem = int'(a % LINE_BYTES);
    return (rem == 0) ? SZ_W'(LINE_BYTES) : SZ_W'(LINE_BYTES - rem);
  endfunction

  task automatic checkIdle(input string req);
    checks++;
    if (portValid !== 1'b0) begin
      errors++;
      $display("FAIL %s: portValid=%b expected 0", req, portValid);
    end
  endtask

  task automatic checkReq(input string req, input logic [ADDR_W-1:0] a,
                          input logic [SLOT_W-1:0] s);
    checks++;
    if (portValid !== 1'b1 || portAddr !== a || portSize !== expSize(a) || portSlot !== s) begin
      errors++;
      $display("FAIL %s: v=%b addr=%h size=%0d slot=%0d expected v=1 addr=%h size=%0d slot=%0d",
               req, portValid, portAddr, portSize, portSlot, a, expSize(a), s);
    end
  endtask

  // drive one cycle's inputs at the falling edge, settle, then return
  task automatic drive(input logic v, input logic [SLOT_W-1:0] s, input int pc,
                       input int occ, input logic [ADDR_W-1:0] b,
                       input logic rdy, input logic rp);
    @(negedge clk);
    grantValid = v; grantSlot = s; grantPc = PC_W'(pc); grantOcc = OCC_W'(occ);
    grantBase = b; portReady = rdy; retryPulse = rp;
    #1;
  endtask

  task automatic idle(input logic rdy, input logic rp);
    drive(1'b0, '0, 0, 0, '0, rdy, rp);
  endtask

  task automatic testReset;
    idle(1'b1, 1'b0);
    checkIdle("R10 reset idle");
  endtask

  task automatic testDirect;
    drive(1'b1, 2'd1, 8, 0, 32'h1000, 1'b1, 1'b0);
    checkReq("R2 aligned full line", expAddr(32'h1000, 8, 0), 2'd1);
    drive(1'b1, 2'd2, 3, 2, 32'h1000, 1'b1, 1'b0);
    checkReq("R3 misaligned trim", 32'h1028, 2'd2);
    drive(1'b1, 2'd3, 0, 7, 32'h2000, 1'b1, 1'b0);
    checkReq("R1 occupancy offset", 32'h2038, 2'd3);
    drive(1'b1, 2'd0, 100, 15, 32'h0003_0004, 1'b1, 1'b0);
    checkReq("R4 slot tag and odd base", expAddr(32'h0003_0004, 100, 15), 2'd0);
    idle(1'b1, 1'b0);
    checkIdle("R5 nothing queued after accepts");
  endtask

  task automatic testRejectOrder;
    logic [ADDR_W-1:0] aA, aB, aC;
    aA = expAddr(32'h4000, 1, 0); aB = expAddr(32'h4000, 9, 1); aC = expAddr(32'h4100, 2, 3);
    drive(1'b1, 2'd0, 1, 0, 32'h4000, 1'b0, 1'b0);
    checkReq("R6 rejected offer shown", aA, 2'd0);
    drive(1'b1, 2'd1, 9, 1, 32'h4000, 1'b1, 1'b0);
    checkIdle("R7 stalled port not offered");
    idle(1'b1, 1'b1);
    checkIdle("R8 retry cycle still stalled");
    drive(1'b1, 2'd2, 2, 3, 32'h4100, 1'b1, 1'b0);
    checkReq("R8 oldest first A", aA, 2'd0);
    idle(1'b1, 1'b0);
    checkReq("R8 then B", aB, 2'd1);
    idle(1'b1, 1'b0);
    checkReq("R8 new grant queued behind C", aC, 2'd2);
    idle(1'b1, 1'b0);
    checkIdle("R8 queue drained");
  endtask

  task automatic testHeadReject;
    logic [ADDR_W-1:0] aD;
    aD = expAddr(32'h8000, 5, 4);
    drive(1'b1, 2'd3, 5, 4, 32'h8000, 1'b0, 1'b0);
    checkReq("R6 reject D", aD, 2'd3);
    idle(1'b0, 1'b1);
    checkIdle("R7 stalled before retry");
    idle(1'b0, 1'b0);
    checkReq("R8 head offered after retry", aD, 2'd3);
    idle(1'b1, 1'b0);
    checkIdle("R6 head rejected again restalls");
    idle(1'b1, 1'b1);
    checkIdle("R8 second retry cycle");
    idle(1'b1, 1'b0);
    checkReq("R8 same head again", aD, 2'd3);
    idle(1'b1, 1'b0);
    checkIdle("R8 empty after head");
  endtask

  task automatic testFill;
    logic [ADDR_W-1:0] a [NUM_SLOTS];
    for (int i = 0; i < NUM_SLOTS; i++) a[i] = expAddr(32'hA000 + 32'(i * 64), i * 3, i);
    drive(1'b1, 2'd0, 0, 0, a[0] - 32'd0, 1'b0, 1'b0);
    checkReq("R9 first rejected", a[0], 2'd0);
    for (int i = 1; i < NUM_SLOTS; i++) begin
      drive(1'b1, SLOT_W'(i), i * 3, i, 32'hA000 + 32'(i * 64), 1'b0, 1'b0);
      checkIdle("R7 stalled while filling");
    end
    idle(1'b1, 1'b1);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      idle(1'b1, 1'b0);
      checkReq("R9 drain order", a[i], SLOT_W'(i));
    end
    idle(1'b1, 1'b0);
    checkIdle("R9 empty after drain");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        testReset();
        testDirect();
        testRejectOrder();
        testHeadReject();
        testFill();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule